// File: doc/BRIEF.md
# Subclock-to-Active Direct Wake Sequencer

This block sequences the jump from the low-rate subclock operating mode straight into full-rate active operation, without passing through an intermediate standby mode. A sleep request is taken as a direct transfer only if four control bits agree: standby select set, low-speed-on clear, direct-transfer-on set, and the timer clock-source bit set. The medium-speed-on bit then selects the active target. Clear selects the high-speed target, where one system state lasts 2 oscillator cycles. Set selects the medium-speed target, where one system state lasts 16 oscillator cycles.

The wake-up runs in two timed phases on two different time bases. The first phase counts 3 subclock states: 2 for the sleep instruction and 1 for internal processing. The subclock arrives as a one-cycle strobe `sub_tick_i`, already synchronised to the oscillator clock `clk_i`. At the end of that phase the CPU clock select moves to the target rate and the CPU clock is held. The controller then counts a programmable stabilisation wait in system states. After the wait it releases the hold and counts 14 system states of interrupt exception handling. When that count ends it pulses a done flag and reports the active mode. Any sleep request that does not match the transfer condition is flagged as ignored and changes nothing.

Top module: `lpm_direct_xfer`

## Requirements
- R1: Reset state: `mode_o`=0 (subactive), `clk_sel_o`=0 (subclock), `clk_hold_o`=0, `exc_done_o`=0 and `req_ignored_o`=0.
- R2: In subactive mode, a sleep request is accepted only with `stby_sel_i`=1, `low_spd_on_i`=0, `direct_on_i`=1 and `tmr_src_i`=1. Any other combination pulses `req_ignored_o` for one cycle after the request edge, and mode and clock select stay 0.
- R3: After acceptance, `clk_sel_o` stays 0 through the first two subclock strobes. On the edge that samples the third strobe, `clk_sel_o` becomes 1 (when `med_spd_on_i`=0) or 2 (when `med_spd_on_i`=1), and `clk_hold_o` rises in the same cycle.
- R4: `clk_hold_o` stays high for exactly N×D oscillator cycles. D is 2 for target 1 and 16 for target 2. N comes from `wait_sel_i` codes 0..7: 8, 16, 32, 64, 1024, 2048, 4096 and 8192 states.
- R5: `exc_done_o` rises exactly 14×D cycles after `clk_hold_o` falls and is high for one cycle only.
- R6: From the cycle `exc_done_o` is high, `mode_o` equals the target (1 high-speed, 2 medium-speed), `clk_sel_o` keeps that same value, and both stay put.
- R7: A sleep request in active mode pulses `req_ignored_o` and leaves `mode_o` and `clk_sel_o` unchanged.
- R8: The target, the wait code and the control bits are captured at acceptance. Changes to them, and further sleep requests, during the transfer change neither its timing nor its target, and they raise no ignored flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_tick_i | input | 1 | One-cycle strobe per subclock state, synchronous to clk_i |
| sleep_req_i | input | 1 | Sleep instruction strobe |
| stby_sel_i | input | 1 | Standby select control bit |
| low_spd_on_i | input | 1 | Low-speed-on control bit |
| med_spd_on_i | input | 1 | Target select: 0 high speed, 1 medium speed |
| direct_on_i | input | 1 | Direct-transfer-on control bit |
| tmr_src_i | input | 1 | Timer clock-source control bit |
| wait_sel_i | input | 3 | Stabilisation wait code |
| mode_o | output | 2 | 0 subactive, 1 active high, 2 active medium |
| clk_sel_o | output | 2 | CPU clock select: 0 subclock, 1 osc/2, 2 osc/16 |
| clk_hold_o | output | 1 | CPU clock held during stabilisation |
| exc_done_o | output | 1 | Exception handling complete pulse |
| req_ignored_o | output | 1 | Sleep request rejected pulse |

## Verification
Every output comes from a register. Each result therefore shows in the cycle after the edge that causes it. The bench drives inputs on falling edges and samples on falling edges, and it counts rising edges with its own counter. The clock select is checked one cycle after each driven subclock strobe. The length of the hold is taken as the difference in edge counts between its rise and its fall, and is compared with N×D. The done pulse is timed from the fall of the hold and compared with 14×D, and it is then checked one cycle later to confirm the pulse is a single cycle. An ignored flag is checked one cycle after the request. In that check the clock select is also confirmed to stay 0 across three later subclock strobes.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    PH_SUBACT = 3'd0,
    PH_SLEEP  = 3'd1,
    PH_STAB   = 3'd2,
    PH_EXC    = 3'd3,
    PH_ACTIVE = 3'd4
  } phase_e;

  localparam logic [1:0] MODE_SUB  = 2'd0;
  localparam logic [1:0] MODE_HIGH = 2'd1;
  localparam logic [1:0] MODE_MED  = 2'd2;

  localparam int unsigned WAIT_SHORT_BASE = 8;
  localparam int unsigned WAIT_LONG_BASE  = 1024;
  localparam int unsigned WAIT_MAX        = WAIT_LONG_BASE << 3;

  // Short codes double from 8, long codes double from 1024.
  function automatic int unsigned standby_states(input logic [2:0] code);
    int unsigned base;
    base = code[2] ? WAIT_LONG_BASE : WAIT_SHORT_BASE;
    return base << code[1:0];
  endfunction

  function automatic logic direct_ok(input logic stby, input logic low_on,
                                     input logic direct, input logic tmr);
    return stby & ~low_on & direct & tmr;
  endfunction

  function automatic logic [1:0] target_code(input logic med);
    return med ? MODE_MED : MODE_HIGH;
  endfunction

endpackage

// File: rtl/dtc_entry_decode.sv
module dtc_entry_decode (
  input  logic       stby_i,
  input  logic       low_on_i,
  input  logic       direct_i,
  input  logic       tmr_i,
  input  logic       med_i,
  output logic       go_o,
  output logic [1:0] target_o
);
  always_comb begin
    go_o     = dtc_pkg::direct_ok(stby_i, low_on_i, direct_i, tmr_i);
    target_o = dtc_pkg::target_code(med_i);
  end
endmodule

// File: rtl/dtc_sys_prescaler.sv
module dtc_sys_prescaler #(
  parameter int HIGH_DIV = 2,
  parameter int MED_DIV  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic med_i,
  output logic tick_o
);
  localparam int MAXD = (MED_DIV > HIGH_DIV) ? MED_DIV : HIGH_DIV;
  localparam int PW   = $clog2(MAXD);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last_w;

  assign last_w = med_i ? PW'(MED_DIV - 1) : PW'(HIGH_DIV - 1);
  assign tick_o = run_i && (cnt_q == last_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (run_i)    cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R4: a system state spans at least two oscillator cycles
  p_tick_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dtc_phase_cnt.sv
module dtc_phase_cnt #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = step_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R4: the phase count never passes its terminal value
  p_cnt_below_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i);
endmodule

// File: rtl/lpm_direct_xfer.sv
module lpm_direct_xfer #(
  parameter int SLP_STATES     = 2,
  parameter int INTPROC_STATES = 1,
  parameter int EXC_STATES     = 14,
  parameter int HIGH_DIV       = 2,
  parameter int MED_DIV        = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sub_tick_i,
  input  logic       sleep_req_i,
  input  logic       stby_sel_i,
  input  logic       low_spd_on_i,
  input  logic       med_spd_on_i,
  input  logic       direct_on_i,
  input  logic       tmr_src_i,
  input  logic [2:0] wait_sel_i,
  output logic [1:0] mode_o,
  output logic [1:0] clk_sel_o,
  output logic       clk_hold_o,
  output logic       exc_done_o,
  output logic       req_ignored_o
);
  import dtc_pkg::*;

  localparam int SUB_TOTAL = SLP_STATES + INTPROC_STATES;
  localparam int CNT_W     = $clog2(WAIT_MAX + 1);

  phase_e     state_q;
  logic [1:0] target_q;
  logic [2:0] wait_q;
  logic       done_q, ign_q;

  logic       go_w;
  logic [1:0] target_w;
  logic       accept_w, hit_w, step_w, sys_tick_w, run_sys_w, clear_w;
  logic       sub_done_w, stab_done_w, exc_done_w, reject_w;
  logic [CNT_W-1:0] limit_w;

  dtc_entry_decode u_decode (
    .stby_i   (stby_sel_i),
    .low_on_i (low_spd_on_i),
    .direct_i (direct_on_i),
    .tmr_i    (tmr_src_i),
    .med_i    (med_spd_on_i),
    .go_o     (go_w),
    .target_o (target_w)
  );

  assign run_sys_w = (state_q == PH_STAB) || (state_q == PH_EXC);

  dtc_sys_prescaler #(.HIGH_DIV(HIGH_DIV), .MED_DIV(MED_DIV)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_sys_w),
    .clear_i (sub_done_w),
    .med_i   (target_q == MODE_MED),
    .tick_o  (sys_tick_w)
  );

  always_comb begin
    unique case (state_q)
      PH_SLEEP: begin step_w = sub_tick_i; limit_w = CNT_W'(SUB_TOTAL); end
      PH_STAB:  begin step_w = sys_tick_w; limit_w = CNT_W'(standby_states(wait_q)); end
      PH_EXC:   begin step_w = sys_tick_w; limit_w = CNT_W'(EXC_STATES); end
      default:  begin step_w = 1'b0;       limit_w = CNT_W'(SUB_TOTAL); end
    endcase
  end

  dtc_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_w),
    .step_i  (step_w),
    .limit_i (limit_w),
    .hit_o   (hit_w)
  );

  // Named phase events
  assign accept_w    = (state_q == PH_SUBACT) && sleep_req_i && go_w;
  assign reject_w    = sleep_req_i && (((state_q == PH_SUBACT) && !go_w) ||
                                       (state_q == PH_ACTIVE));
  assign sub_done_w  = (state_q == PH_SLEEP) && hit_w;
  assign stab_done_w = (state_q == PH_STAB)  && hit_w;
  assign exc_done_w  = (state_q == PH_EXC)   && hit_w;
  assign clear_w     = accept_w || hit_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_SUBACT;
      target_q <= MODE_HIGH;
      wait_q   <= '0;
      done_q   <= 1'b0;
      ign_q    <= 1'b0;
    end else begin
      done_q <= exc_done_w;
      ign_q  <= reject_w;
      if (accept_w) begin
        state_q  <= PH_SLEEP;
        target_q <= target_w;
        wait_q   <= wait_sel_i;
      end else if (sub_done_w) begin
        state_q <= PH_STAB;
      end else if (stab_done_w) begin
        state_q <= PH_EXC;
      end else if (exc_done_w) begin
        state_q <= PH_ACTIVE;
      end
    end
  end

  assign mode_o        = (state_q == PH_ACTIVE) ? target_q : MODE_SUB;
  assign clk_sel_o     = (run_sys_w || state_q == PH_ACTIVE) ? target_q : MODE_SUB;
  assign clk_hold_o    = (state_q == PH_STAB);
  assign exc_done_o    = done_q;
  assign req_ignored_o = ign_q;

  // R3: clock held only once a target rate is selected
  p_hold_has_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_hold_o |-> (clk_sel_o != MODE_SUB));
  // R3: clock select moves only at the subclock/system phase boundary
  p_sel_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_o != $past(clk_sel_o)) |-> $past(sub_done_w));
  // R5: done is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_done_o |=> !exc_done_o);
  // R6: at done the reported mode is the selected active rate
  p_done_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_done_o |-> ((mode_o != MODE_SUB) && (mode_o == clk_sel_o)));
  // R2: a rejected request leaves the mode alone
  p_ignored_keeps_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ignored_o |-> $stable(mode_o));
  // R8: target stays fixed through exception handling
  p_target_latched_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_EXC) |-> $stable(clk_sel_o));
endmodule

// File: tb/lpm_direct_xfer_tb_top.sv
module lpm_direct_xfer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick = 1'b0, sleep_req = 1'b0;
  logic       stby = 1'b1, low_on = 1'b0, med = 1'b0, direct = 1'b1, tmr = 1'b1;
  logic [2:0] wsel = 3'd0;
  logic [1:0] mode, csel;
  logic       hold, done, ign;
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  lpm_direct_xfer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sub_tick_i(sub_tick), .sleep_req_i(sleep_req),
    .stby_sel_i(stby), .low_spd_on_i(low_on), .med_spd_on_i(med),
    .direct_on_i(direct), .tmr_src_i(tmr), .wait_sel_i(wsel),
    .mode_o(mode), .clk_sel_o(csel), .clk_hold_o(hold),
    .exc_done_o(done), .req_ignored_o(ign));

  // stim: bit3 = medium target, bits 2:0 = wait code
  localparam logic [3:0] VEC [7] = '{4'h0, 4'h8, 4'h3, 4'hB, 4'h4, 4'h9, 4'h7};

  function automatic int exp_wait(input logic [2:0] c);
    case (c)
      3'd0: return 8;    3'd1: return 16;   3'd2: return 32;   3'd3: return 64;
      3'd4: return 1024; 3'd5: return 2048; 3'd6: return 4096; default: return 8192;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_tick();
    repeat (3) @(negedge clk);
    sub_tick = 1'b1; @(negedge clk); sub_tick = 1'b0;
  endtask

  task automatic run_xfer(input logic m, input logic [2:0] c, input bit disturb);
    int d, n, t0, th, td, g;
    bit ign_seen;
    d = m ? 16 : 2;
    n = exp_wait(c);
    med = m; wsel = c; stby = 1; low_on = 0; direct = 1; tmr = 1;
    @(negedge clk);
    pulse_sleep();
    for (int k = 1; k <= 3; k++) begin
      pulse_tick();
      if (k < 3) check(csel == 2'd0, "R3 select before third strobe", csel, 0);
    end
    check(csel == (m ? 2'd2 : 2'd1), "R3 select after third strobe", csel, m ? 2 : 1);
    check(hold == 1'b1, "R3 hold at boundary", hold, 1);
    t0 = cyc; g = 0; ign_seen = 0;
    while (hold && g < 40000) begin
      if (disturb && g == 1) begin
        med = ~m; wsel = ~c; low_on = 1; sleep_req = 1;
      end else sleep_req = 0;
      @(negedge clk); g++;
      if (ign) ign_seen = 1;
    end
    sleep_req = 0;
    th = cyc;
    check(th - t0 == n * d, disturb ? "R8 hold length under input changes" : "R4 hold length",
          th - t0, n * d);
    g = 0;
    while (!done && g < 40000) begin
      @(negedge clk); g++;
      if (ign) ign_seen = 1;
    end
    td = cyc;
    check(td - th == 14 * d, "R5 exception length", td - th, 14 * d);
    check(mode == (m ? 2'd2 : 2'd1), "R6 mode at done", mode, m ? 2 : 1);
    if (disturb) check(!ign_seen, "R8 no ignored flag during transfer", ign_seen, 0);
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", done, 0);
    check(mode == (m ? 2'd2 : 2'd1) && csel == mode, "R6 mode holds", mode, m ? 2 : 1);
  endtask

  task automatic reject_case(input logic s, input logic l, input logic dr, input logic t);
    do_reset();
    stby = s; low_on = l; direct = dr; tmr = t;
    @(negedge clk);
    pulse_sleep();
    check(ign == 1'b1, "R2 ignored flag", ign, 1);
    check(mode == 2'd0, "R2 mode unchanged", mode, 0);
    @(negedge clk);
    check(ign == 1'b0, "R2 ignored one cycle", ign, 0);
    for (int k = 0; k < 3; k++) pulse_tick();
    check(csel == 2'd0 && hold == 1'b0, "R2 no transfer started", csel, 0);
    stby = 1; low_on = 0; direct = 1; tmr = 1;
  endtask

  initial begin
    while (cyc < 190000) @(negedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(mode == 0 && csel == 0 && hold == 0 && done == 0 && ign == 0,
          "R1 reset outputs", {mode, csel, hold, done, ign}, 0);

    foreach (VEC[i]) begin
      do_reset();
      run_xfer(VEC[i][3], VEC[i][2:0], 1'b0);
    end

    // R7: sleep in active mode is ignored
    pulse_sleep();
    check(ign == 1'b1, "R7 ignored in active", ign, 1);
    check(mode == 2'd1 && csel == 2'd1, "R7 mode kept", mode, 1);

    // R2: each failing control bit
    reject_case(1'b0, 1'b0, 1'b1, 1'b1);
    reject_case(1'b1, 1'b1, 1'b1, 1'b1);
    reject_case(1'b1, 1'b0, 1'b0, 1'b1);
    reject_case(1'b1, 1'b0, 1'b1, 1'b0);

    // R8: inputs disturbed mid-transfer
    do_reset();
    run_xfer(1'b1, 3'd2, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule